// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes a serial input line and turns each asynchronous frame on it into a parallel character for a host. A frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a high stop bit. The frame format and the bit-rate factor are inputs that can change at run time, and they use the same codes as the companion transmitter. The receive clock reaches the block as a one-cycle tick on the system clock, one tick for each rising edge of the receive clock. The factor sets how many ticks make up one bit time: 1, 16 or 64.

The serial line passes through a two-flop synchronizer before it is sampled. With oversampling, a falling edge is checked again at the middle of the start bit, and every later bit is taken at its own midpoint. With a factor of 1, the block acts on the line at every tick and does not check the start bit.

Each finished character is stored in a holding register, and a ready flag is raised. A host read strobe clears the ready flag. Parity, framing and overrun errors set separate flags. These flags stay set until an error-reset pulse arrives.

Top module: `serial_char_receiver`

## Requirements
- R1: Character length is coded by `char_len` as 00=5, 01=6, 10=7 and 11=8 bits, received least significant bit first. The character is right-aligned in `rx_data`, and the unused upper bits read 0.
- R2: `baud_sel` codes the ticks per bit as 01=1, 10=16 and 11=64. Code 00 behaves as 01. At 16 and 64, each data, parity and stop bit is sampled a whole number of bit times after the start-bit midpoint.
- R3: At 16 and 64, a low level is confirmed at the start-bit midpoint, which is 8 or 32 ticks after it is first seen. If the line is high again at that point, the block returns to idle and produces no character.
- R4: At factor 1, a low line seen on a tick starts a frame, and the next tick samples data bit 0.
- R5: `rx_ready` rises when a character completes and falls after a `host_rd` pulse. It does not fall otherwise.
- R6: When `parity_en` is 1, the received parity bit is compared with the expected bit. For even sense (`parity_even`=1) the expected bit is the XOR of the data bits; for odd sense it is the inverse of that XOR. A mismatch sets `parity_err`. When `parity_en` is 0, no parity bit is expected.
- R7: A low line at the stop-bit sample sets `framing_err`.
- R8: If a character completes while `rx_ready` is still 1 and no `host_rd` arrives in that cycle, `overrun_err` is set. The new character replaces the old one in `rx_data`.
- R9: The three error flags are sticky until an `err_reset` pulse clears them. A flag being set in the same cycle takes priority over the clear.
- R10: While `rx_enable` is 0, any frame in progress is dropped and the line is ignored. `rx_data` and `rx_ready` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| rxc_tick | input | 1 | One-cycle pulse for each receive-clock rising edge |
| rx_enable | input | 1 | Receiver enable |
| char_len | input | 2 | Character length code |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 = even parity, 0 = odd parity |
| baud_sel | input | 2 | Ticks-per-bit code |
| host_rd | input | 1 | Host read strobe, clears ready |
| err_reset | input | 1 | Clears the error flags |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | Character available |
| parity_err | output | 1 | Sticky parity error |
| framing_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun error |

## Verification
Assertions check the following on every cycle:
- `rx_ready` falls only after a read, and each error flag falls only after an error reset.
- An overrun appears only while a character was already pending.
- A parity error appears only with parity enabled.
- The held character changes only at a completion.
- Disabling the receiver returns it to idle.

The correctness of the recovered bits and of the flag values needs the bench's scenarios. These cover random formats and factors, bad parity, a low stop bit, a rejected start glitch, back-to-back characters without a read, and frames sent while the receiver is disabled.

// File: rtl/serial_char_receiver.sv
module serial_char_receiver #(
  parameter int X16_DIV = 16,
  parameter int X64_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       rxc_tick,
  input  logic       rx_enable,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic [1:0] baud_sel,
  input  logic       host_rd,
  input  logic       err_reset,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       parity_err,
  output logic       framing_err,
  output logic       overrun_err
);

  localparam int CNT_W = $clog2(X64_DIV);
  localparam logic [CNT_W-1:0] F16 = CNT_W'(X16_DIV - 1);
  localparam logic [CNT_W-1:0] F64 = CNT_W'(X64_DIV - 1);
  localparam logic [CNT_W-1:0] H16 = CNT_W'(X16_DIV / 2 - 1);
  localparam logic [CNT_W-1:0] H64 = CNT_W'(X64_DIV / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              state;
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;
  logic             par_bit;

  wire line = sync_q[1];
  wire oversample = baud_sel[1];
  wire [CNT_W-1:0] full_m1 = (baud_sel == 2'b11) ? F64 : (baud_sel == 2'b10) ? F16 : '0;
  wire [CNT_W-1:0] half_m1 = (baud_sel == 2'b11) ? H64 : H16;
  wire [2:0] last_idx = {1'b1, char_len};
  wire at_bit = rxc_tick && (cnt == full_m1);
  wire complete = rx_enable && at_bit && (state == S_STOP);
  wire par_bad = parity_en && (par_bit != (^shreg ^ ~parity_even));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
    end else if (!rx_enable) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (rxc_tick) begin
      case (state)
        S_IDLE:
          if (!line) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            state   <= oversample ? S_START : S_DATA;
          end
        S_START:
          if (cnt == half_m1) begin
            cnt   <= '0;
            state <= line ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (at_bit) begin
            cnt            <= '0;
            shreg[bit_idx] <= line;
            if (bit_idx == last_idx) state <= parity_en ? S_PAR : S_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        S_PAR:
          if (at_bit) begin
            cnt     <= '0;
            par_bit <= line;
            state   <= S_STOP;
          end else cnt <= cnt + 1'b1;
        S_STOP:
          if (at_bit) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      if (complete) rx_data <= shreg;

      if (complete)     rx_ready <= 1'b1;
      else if (host_rd) rx_ready <= 1'b0;

      if (complete && rx_ready && !host_rd) overrun_err <= 1'b1;
      else if (err_reset)                   overrun_err <= 1'b0;

      if (complete && par_bad) parity_err <= 1'b1;
      else if (err_reset)      parity_err <= 1'b0;

      if (complete && !line) framing_err <= 1'b1;
      else if (err_reset)    framing_err <= 1'b0;
    end
  end

  assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(host_rd));

  assert_sticky_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parity_err) |-> $past(err_reset));

  assert_sticky_framing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(framing_err) |-> $past(err_reset));

  assert_sticky_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun_err) |-> $past(err_reset));

  assert_overrun_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(rx_ready));

  assert_parity_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_err) |-> $past(parity_en));

  assert_data_on_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_ready);

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> state == S_IDLE);

endmodule

// File: tb/serial_char_receiver_bench.sv
module serial_char_receiver_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, rxd = 1, rxc_tick = 0, rx_enable = 1;
  logic [1:0] char_len = 2'b11, baud_sel = 2'b10;
  logic parity_en = 0, parity_even = 0, host_rd = 0, err_reset = 0;
  logic [7:0] rx_data;
  logic rx_ready, parity_err, framing_err, overrun_err;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_char_receiver u_serial_char_receiver (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rxc_tick(rxc_tick), .rx_enable(rx_enable),
    .char_len(char_len), .parity_en(parity_en), .parity_even(parity_even),
    .baud_sel(baud_sel), .host_rd(host_rd), .err_reset(err_reset),
    .rx_data(rx_data), .rx_ready(rx_ready), .parity_err(parity_err),
    .framing_err(framing_err), .overrun_err(overrun_err));

  function automatic logic [7:0] mask_of(input logic [1:0] cl);
    return 8'hFF >> (3 - cl);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic even);
    return even ? ^d : ~^d;
  endfunction

  function automatic int factor_of(input logic [1:0] bs);
    return (bs == 2'b11) ? 64 : (bs == 2'b10) ? 16 : 1;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) rxc_tick = 1;
    @(negedge clk) rxc_tick = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_rd();
    @(negedge clk) host_rd = 1;
    @(negedge clk) host_rd = 0;
  endtask

  task automatic pulse_er();
    @(negedge clk) err_reset = 1;
    @(negedge clk) err_reset = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic flip_par, input logic low_stop);
    int f = factor_of(baud_sel);
    hold(1'b0, f);
    for (int i = 0; i <= 4 + int'(char_len); i++) hold(d[i], f);
    if (parity_en) hold(par_of(d & mask_of(char_len), parity_even) ^ flip_par, f);
    hold(!low_stop, f);
    hold(1'b1, 2 * f + 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d, keep;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rx_ready, 0, "R5 reset ready");
    chk(rx_data, 0, "R1 reset data");
    chk({parity_err, framing_err, overrun_err}, 0, "R9 reset flags");

    // directed 8-bit even parity at x16
    char_len = 2'b11; parity_en = 1; parity_even = 1; baud_sel = 2'b10;
    send(8'hA5, 0, 0);
    chk(rx_ready, 1, "R5 ready set");
    chk(rx_data, 8'hA5, "R2 x16 data");
    chk(parity_err, 0, "R6 good even parity");
    pulse_rd();
    chk(rx_ready, 0, "R5 read clears");

    // x1, 5 bits, odd parity
    char_len = 2'b00; parity_even = 0; baud_sel = 2'b01;
    send(8'hFD, 0, 0);
    chk(rx_data, 8'h1D, "R4 x1 5-bit data");
    chk(parity_err, 0, "R6 good odd parity");
    pulse_rd();

    // x64, 7 bits, no parity
    char_len = 2'b10; parity_en = 0; baud_sel = 2'b11;
    send(8'h3C, 0, 0);
    chk(rx_data, 8'h3C, "R2 x64 7-bit data");
    pulse_rd();

    // parity error, then sticky across a good frame
    char_len = 2'b11; parity_en = 1; parity_even = 1; baud_sel = 2'b10;
    send(8'h5A, 1, 0);
    chk(parity_err, 1, "R6 bad parity flagged");
    pulse_rd();
    send(8'h11, 0, 0);
    chk(parity_err, 1, "R9 parity sticky");
    chk(rx_data, 8'h11, "R1 data after error");
    pulse_er();
    chk(parity_err, 0, "R9 err_reset clears parity");
    pulse_rd();

    // framing error
    parity_en = 0;
    send(8'h77, 0, 1);
    chk(framing_err, 1, "R7 low stop flagged");
    chk(rx_ready, 1, "R7 char still delivered");
    pulse_rd();
    pulse_er();
    chk(framing_err, 0, "R9 err_reset clears framing");

    // overrun with replacement
    send(8'h12, 0, 0);
    send(8'h34, 0, 0);
    chk(overrun_err, 1, "R8 overrun flagged");
    chk(rx_data, 8'h34, "R8 new char replaces");
    pulse_er();
    chk(overrun_err, 0, "R9 err_reset clears overrun");
    chk(rx_ready, 1, "R5 err_reset keeps ready");
    pulse_rd();

    // start glitch rejected at x16
    keep = rx_data;
    hold(1'b0, 4);
    hold(1'b1, 40);
    chk(rx_ready, 0, "R3 glitch no char");
    chk(rx_data, keep, "R3 glitch data kept");
    send(8'hC3, 0, 0);
    chk(rx_data, 8'hC3, "R3 good frame after glitch");
    pulse_rd();

    // disabled receiver ignores line
    keep = rx_data;
    rx_enable = 0;
    send(8'h0F, 0, 0);
    chk(rx_ready, 0, "R10 disabled no ready");
    chk(rx_data, keep, "R10 disabled data kept");
    rx_enable = 1;
    hold(1'b1, 4);

    // random formats
    for (int n = 0; n < 24; n++) begin
      char_len = 2'($urandom_range(0, 3));
      parity_en = 1'($urandom_range(0, 1));
      parity_even = 1'($urandom_range(0, 1));
      baud_sel = (n % 6 == 5) ? 2'b11 : 2'($urandom_range(1, 2));
      d = 8'($urandom);
      hold(1'b1, 3);
      send(d, 0, 0);
      chk(rx_ready, 1, "R5 random ready");
      chk(rx_data, d & mask_of(char_len), "R1 random data");
      chk({parity_err, framing_err, overrun_err}, 0, "R6 random flags clear");
      pulse_rd();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule